// File: doc/BRIEF.md
# Read Clock/Strobe Delay Training Sweep

This block calibrates the read path of a DRAM interface. It drives a clock-lane delay code and a data-strobe delay code to the PHY. For each setting it clears the sticky failure flag, triggers a read-pipe test, and takes the pass/fail result when test-done arrives. In a two-dimensional grid it counts, for every clock candidate, how many strobe candidates pass. It then picks the clock candidate in the middle of the best-scoring window. With that clock setting it sweeps the strobe candidates again and centres within the passing strobe window. A last test at the chosen pair gives the training result.

Edge-bias rules move the centre toward a window that touches either end of the candidate list. When the centred candidate is weaker than the window's best, the lowest index of the window is used instead. If nothing passes, both delays fall back to the zero code. A timeout aborts the run with a failure when the test engine does not answer in time. The results stay on the outputs until the next start.

Top module: `rdq_train_ctl`

## Requirements
- R1: After reset, busy, done, pass, test_go and fail_clr are all 0.
- R2: Clock candidate indices 0..14 map to the 6-bit codes 07,06,05,04,03,02,01,00,08,10,18,20,28,30,38 (hex), and strobe indices 0..6 map to the 4-bit codes 3,2,1,0,E,D,C. The grid runs the clock index as the outer loop and the strobe index as the inner loop, both ascending, for 105 tests. A full run has 113 tests: the grid, then 7 strobe tests, then the final test.
- R3: test_go fires only after the codes have been steady for at least SETTLE_CYC cycles, and fail_clr pulses in the cycle directly before every test_go.
- R4: test_pass is taken only in a cycle where test_done is high. Its value in other cycles has no effect.
- R5: Clock choice: let best be the highest per-clock pass count, and let lo and hi be the lowest and highest clock indices that reach it. The centre is m=(lo+hi)>>1. If hi=14 and lo>0, m=(15+m)>>1. Otherwise, if lo=0 and hi<14, m=m>>1.
- R6: If the pass count at the centred clock index is below best, the clock index lo is used instead.
- R7: The strobe sweep at the chosen clock setting uses the R5 rules with 7 candidates. If the centred strobe index failed, the lowest passing strobe index is used.
- R8: If no test passes in the grid (106 tests in total), or none passes in the strobe sweep, the codes fall back to zero: clock index 7 and strobe index 3. A final test is then run at that setting.
- R9: The result of the final test is the pass output. done rises with it and busy falls.
- R10: If test_done does not arrive within TMO_CYC cycles of test_go, the run ends with done=1 and pass=0, and no further test is issued.
- R11: While done is high and start is low, done, pass, both indices and both codes hold their values.
- R12: test_go and fail_clr are single-cycle pulses and are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begins a training run when idle or finished |
| test_done | input | 1 | Read-pipe test finished (one-cycle strobe) |
| test_pass | input | 1 | Test outcome, valid with test_done |
| test_go | output | 1 | Trigger pulse for one read-pipe test |
| fail_clr | output | 1 | Pulse clearing the test engine's sticky failure flag |
| clk_code | output | 6 | Clock-lane delay code to the PHY |
| dqs_code | output | 4 | Strobe delay code, shared by all data lanes |
| busy | output | 1 | Training in progress |
| done | output | 1 | Training finished, results valid |
| pass | output | 1 | Final training result |
| clk_idx | output | 4 | Current or chosen clock candidate index |
| dqs_idx | output | 3 | Current or chosen strobe candidate index |

## Verification
The checker watches several rules on every cycle: settle time before each trigger, the clear pulse before it, single-cycle trigger pulses, index ranges, the timeout bound on an outstanding test, and result stability while done is held. The window-centring arithmetic, both fallbacks, the grid order and the total test count show only in whole runs. For these, the bench's responder model answers from a pass map, and the bench works out the expected indices from the same map. The maps cover interior windows, windows touching either end or both ends, a weak centre, a gapped strobe row, no passes at all, a strobe sweep that fails outright, and a muted responder.

// File: rtl/rdq_train_pkg.sv
package rdq_train_pkg;
  localparam int CLK_N = 15;
  localparam int DQS_N = 7;
  localparam int CLK_W = 6;
  localparam int DQS_W = 4;
  localparam int CI_W = $clog2(CLK_N);
  localparam int DI_W = $clog2(DQS_N);
  localparam int CNT_W = $clog2(DQS_N + 1);
  localparam int CLK_ZERO_IDX = 7;
  localparam int DQS_ZERO_IDX = 3;

  typedef enum logic [2:0] {
    S_IDLE, S_SETTLE, S_CLR, S_GO, S_WAIT, S_PICK_C, S_PICK_D, S_FINISH
  } st_t;

  typedef enum logic [1:0] {PH_GRID, PH_LINE, PH_LAST} ph_t;

  function automatic logic [CLK_W-1:0] clk_code_of(input logic [CI_W-1:0] i);
    case (i)
      4'd0: return 6'h07;
      4'd1: return 6'h06;
      4'd2: return 6'h05;
      4'd3: return 6'h04;
      4'd4: return 6'h03;
      4'd5: return 6'h02;
      4'd6: return 6'h01;
      4'd7: return 6'h00;
      4'd8: return 6'h08;
      4'd9: return 6'h10;
      4'd10: return 6'h18;
      4'd11: return 6'h20;
      4'd12: return 6'h28;
      4'd13: return 6'h30;
      4'd14: return 6'h38;
      default: return 6'h00;
    endcase
  endfunction

  function automatic logic [DQS_W-1:0] dqs_code_of(input logic [DI_W-1:0] i);
    case (i)
      3'd0: return 4'h3;
      3'd1: return 4'h2;
      3'd2: return 4'h1;
      3'd3: return 4'h0;
      3'd4: return 4'hE;
      3'd5: return 4'hD;
      3'd6: return 4'hC;
      default: return 4'h0;
    endcase
  endfunction

  // Centre of window [lo,hi] among n candidates, biased toward an open end.
  function automatic int centre_idx(input int lo, input int hi, input int n);
    int m;
    m = (lo + hi) >> 1;
    if (hi == n - 1 && lo > 0) m = (n + m) >> 1;
    else if (hi < n - 1 && lo == 0) m = m >> 1;
    return m;
  endfunction
endpackage

// File: rtl/rdq_cycle_timer.sv
module rdq_cycle_timer #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  output logic [W-1:0] cnt
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt <= '0;
    else if (clr) cnt <= '0;
    else if (cnt != {W{1'b1}}) cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/rdq_window_pick.sv
module rdq_window_pick
  import rdq_train_pkg::*;
#(
  parameter int N  = 15,
  parameter int CW = 3,
  parameter int IW = $clog2(N)
) (
  input  logic [N*CW-1:0] counts,
  output logic            found,
  output logic [IW-1:0]   pick
);
  logic [CW-1:0] best;
  int lo, hi, c;

  always_comb begin
    best = '0;
    for (int i = 0; i < N; i++)
      if (counts[i*CW +: CW] > best) best = counts[i*CW +: CW];
    lo = 0;
    hi = 0;
    for (int i = N - 1; i >= 0; i--)
      if (best != '0 && counts[i*CW +: CW] == best) lo = i;
    for (int i = 0; i < N; i++)
      if (best != '0 && counts[i*CW +: CW] == best) hi = i;
    c = centre_idx(lo, hi, N);
    if (counts[c*CW +: CW] < best) c = lo;
    found = (best != '0);
    pick = IW'(c);
  end
endmodule

// File: rtl/rdq_train_ctl.sv
module rdq_train_ctl
  import rdq_train_pkg::*;
#(
  parameter int SETTLE_CYC = 100,
  parameter int TMO_CYC    = 1000
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             test_done,
  input  logic             test_pass,
  output logic             test_go,
  output logic             fail_clr,
  output logic [CLK_W-1:0] clk_code,
  output logic [DQS_W-1:0] dqs_code,
  output logic             busy,
  output logic             done,
  output logic             pass,
  output logic [CI_W-1:0]  clk_idx,
  output logic [DI_W-1:0]  dqs_idx
);
  localparam int TMAX = (SETTLE_CYC > TMO_CYC) ? SETTLE_CYC : TMO_CYC;
  localparam int TW   = $clog2(TMAX + 1);

  st_t st;
  ph_t ph;
  logic [CI_W-1:0]  ci;
  logic [DI_W-1:0]  di;
  logic [CNT_W-1:0] gcnt [CLK_N];
  logic [DQS_N-1:0] line_pass;
  logic             done_q, pass_q;

  // Named internal events
  logic [TW-1:0]          tmr;
  logic                   tmr_clr, settle_end, wait_tmo, last_dqs, last_clk;
  logic [CLK_N*CNT_W-1:0] gcnt_flat;
  logic                   clk_found, dqs_found;
  logic [CI_W-1:0]        clk_pick;
  logic [DI_W-1:0]        dqs_pick;

  assign tmr_clr    = (st != S_SETTLE && st != S_WAIT) || (st == S_WAIT && test_done);
  assign settle_end = (st == S_SETTLE) && (tmr == TW'(SETTLE_CYC - 1));
  assign wait_tmo   = (st == S_WAIT) && !test_done && (tmr == TW'(TMO_CYC - 1));
  assign last_dqs   = (di == DI_W'(DQS_N - 1));
  assign last_clk   = (ci == CI_W'(CLK_N - 1));

  rdq_cycle_timer #(.W(TW)) u_tmr (
    .clk(clk), .rst_n(rst_n), .clr(tmr_clr), .cnt(tmr)
  );

  for (genvar g = 0; g < CLK_N; g++) begin : g_pack
    assign gcnt_flat[g*CNT_W +: CNT_W] = gcnt[g];
  end

  rdq_window_pick #(.N(CLK_N), .CW(CNT_W), .IW(CI_W)) u_pick_clk (
    .counts(gcnt_flat), .found(clk_found), .pick(clk_pick)
  );

  rdq_window_pick #(.N(DQS_N), .CW(1), .IW(DI_W)) u_pick_dqs (
    .counts(line_pass), .found(dqs_found), .pick(dqs_pick)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st        <= S_IDLE;
      ph        <= PH_GRID;
      ci        <= '0;
      di        <= '0;
      line_pass <= '0;
      done_q    <= 1'b0;
      pass_q    <= 1'b0;
      for (int i = 0; i < CLK_N; i++) gcnt[i] <= '0;
    end else begin
      case (st)
        S_IDLE, S_FINISH: begin
          if (start) begin
            st        <= S_SETTLE;
            ph        <= PH_GRID;
            ci        <= '0;
            di        <= '0;
            line_pass <= '0;
            done_q    <= 1'b0;
            pass_q    <= 1'b0;
            for (int i = 0; i < CLK_N; i++) gcnt[i] <= '0;
          end
        end
        S_SETTLE: if (settle_end) st <= S_CLR;
        S_CLR:    st <= S_GO;
        S_GO:     st <= S_WAIT;
        S_WAIT: begin
          if (test_done) begin
            case (ph)
              PH_GRID: begin
                if (test_pass) gcnt[ci] <= gcnt[ci] + 1'b1;
                if (!last_dqs) begin
                  di <= di + 1'b1;
                  st <= S_SETTLE;
                end else begin
                  di <= '0;
                  if (!last_clk) begin
                    ci <= ci + 1'b1;
                    st <= S_SETTLE;
                  end else st <= S_PICK_C;
                end
              end
              PH_LINE: begin
                line_pass[di] <= test_pass;
                if (!last_dqs) begin
                  di <= di + 1'b1;
                  st <= S_SETTLE;
                end else st <= S_PICK_D;
              end
              default: begin
                pass_q <= test_pass;
                done_q <= 1'b1;
                st     <= S_FINISH;
              end
            endcase
          end else if (wait_tmo) begin
            pass_q <= 1'b0;
            done_q <= 1'b1;
            st     <= S_FINISH;
          end
        end
        S_PICK_C: begin
          st <= S_SETTLE;
          if (clk_found) begin
            ci <= clk_pick;
            di <= '0;
            ph <= PH_LINE;
          end else begin
            ci <= CI_W'(CLK_ZERO_IDX);
            di <= DI_W'(DQS_ZERO_IDX);
            ph <= PH_LAST;
          end
        end
        S_PICK_D: begin
          st <= S_SETTLE;
          ph <= PH_LAST;
          if (dqs_found) di <= dqs_pick;
          else begin
            ci <= CI_W'(CLK_ZERO_IDX);
            di <= DI_W'(DQS_ZERO_IDX);
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  assign fail_clr = (st == S_CLR);
  assign test_go  = (st == S_GO);
  assign busy     = (st != S_IDLE) && (st != S_FINISH);
  assign done     = done_q;
  assign pass     = pass_q;
  assign clk_idx  = ci;
  assign dqs_idx  = di;
  assign clk_code = clk_code_of(ci);
  assign dqs_code = dqs_code_of(di);
endmodule

// File: rtl/rdq_train_chk.sv
module rdq_train_chk
  import rdq_train_pkg::*;
#(
  parameter int SETTLE_CYC = 100,
  parameter int TMO_CYC    = 1000
) (
  input logic             clk,
  input logic             rst_n,
  input logic             start,
  input logic             test_go,
  input logic             fail_clr,
  input logic             test_done,
  input logic             busy,
  input logic             done,
  input logic             pass,
  input logic [CI_W-1:0]  clk_idx,
  input logic [DI_W-1:0]  dqs_idx,
  input logic [CLK_W-1:0] clk_code,
  input logic [DQS_W-1:0] dqs_code
);
  localparam int SW = $clog2(SETTLE_CYC + 2) + 1;
  localparam int WW = $clog2(TMO_CYC + 2) + 1;

  logic [CLK_W-1:0] prev_cc;
  logic [DQS_W-1:0] prev_dc;
  logic [SW-1:0]    stl_cnt;
  logic [WW-1:0]    wcnt;
  logic             outst;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_cc <= '0;
      prev_dc <= '0;
      stl_cnt <= '0;
      wcnt    <= '0;
      outst   <= 1'b0;
    end else begin
      prev_cc <= clk_code;
      prev_dc <= dqs_code;
      if (clk_code != prev_cc || dqs_code != prev_dc) stl_cnt <= '0;
      else if (stl_cnt != {SW{1'b1}}) stl_cnt <= stl_cnt + 1'b1;
      if (test_go) begin
        outst <= 1'b1;
        wcnt  <= '0;
      end else if (test_done || done) begin
        outst <= 1'b0;
        wcnt  <= '0;
      end else if (outst && wcnt != {WW{1'b1}}) wcnt <= wcnt + 1'b1;
    end
  end

  p_idx_range_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (clk_idx < CI_W'(CLK_N)) && (dqs_idx < DI_W'(DQS_N)));

  p_clr_before_go_r3: assert property (@(posedge clk) disable iff (!rst_n)
    test_go |-> $past(fail_clr));

  p_settle_r3: assert property (@(posedge clk) disable iff (!rst_n)
    test_go |-> (stl_cnt >= SW'(SETTLE_CYC)));

  p_done_not_busy_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !(busy && done));

  p_timeout_r10: assert property (@(posedge clk) disable iff (!rst_n)
    outst |-> (wcnt <= WW'(TMO_CYC)));

  p_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !start) |=> (done && $stable(pass) && $stable(clk_idx) && $stable(dqs_idx)));

  p_pulse_excl_r12: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({test_go, fail_clr}));

  p_go_single_r12: assert property (@(posedge clk) disable iff (!rst_n)
    test_go |=> !test_go);
endmodule

bind rdq_train_ctl rdq_train_chk #(.SETTLE_CYC(SETTLE_CYC), .TMO_CYC(TMO_CYC)) u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .test_go(test_go), .fail_clr(fail_clr),
  .test_done(test_done), .busy(busy), .done(done), .pass(pass),
  .clk_idx(clk_idx), .dqs_idx(dqs_idx), .clk_code(clk_code), .dqs_code(dqs_code)
);

// File: tb/rdq_train_ctl_test.sv
module rdq_train_ctl_test;
  localparam int CLK_PERIOD = 10;
  localparam int SETTLE = 4;
  localparam int TMO = 20;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic test_done = 1'b0;
  logic test_pass = 1'b1;
  logic test_go, fail_clr, busy, done, pass;
  logic [5:0] clk_code;
  logic [3:0] dqs_code;
  logic [3:0] clk_idx;
  logic [2:0] dqs_idx;

  int checks = 0;
  int errors = 0;
  logic [6:0] pm [15];
  int go_count = 0, clr_bad = 0, order_bad = 0, mute_at = -1;
  bit line_kill = 0, line_expected = 0, clr_seen = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  rdq_train_ctl #(.SETTLE_CYC(SETTLE), .TMO_CYC(TMO)) uut (
    .clk(clk), .rst_n(rst_n), .start(start), .test_done(test_done), .test_pass(test_pass),
    .test_go(test_go), .fail_clr(fail_clr), .clk_code(clk_code), .dqs_code(dqs_code),
    .busy(busy), .done(done), .pass(pass), .clk_idx(clk_idx), .dqs_idx(dqs_idx)
  );

  function automatic int ccode(input int i);
    return (i < 8) ? (7 - i) : ((i - 7) * 8);
  endfunction

  function automatic int dcode(input int j);
    return (j < 4) ? (3 - j) : (18 - j);
  endfunction

  function automatic int cdec(input int code);
    for (int i = 0; i < 15; i++) if (ccode(i) == code) return i;
    return 0;
  endfunction

  function automatic int ddec(input int code);
    for (int j = 0; j < 7; j++) if (dcode(j) == code) return j;
    return 0;
  endfunction

  function automatic int mid_of(input int lo, input int hi, input int n);
    int m = (lo + hi) / 2;
    if (hi == n - 1 && lo != 0) m = (m + n) / 2;
    else if (lo == 0 && hi != n - 1) m = m / 2;
    return m;
  endfunction

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // Responder: models the read-pipe test engine from the pass map pm.
  initial begin
    forever begin
      @(negedge clk);
      if (test_go) begin
        go_count++;
        if (!clr_seen) clr_bad++;
        clr_seen = 0;
        if (go_count <= 105) begin
          if (clk_code != ccode((go_count - 1) / 7) || dqs_code != dcode((go_count - 1) % 7))
            order_bad++;
        end else if (line_expected && go_count <= 112) begin
          if (dqs_code != dcode(go_count - 106)) order_bad++;
        end
        if (go_count != mute_at) begin
          automatic bit r = pm[cdec(clk_code)][ddec(dqs_code)];
          if (line_kill && go_count > 105 && go_count <= 112) r = 0;
          repeat (2) @(negedge clk);
          test_pass = r;
          test_done = 1'b1;
          @(negedge clk);
          test_done = 1'b0;
          test_pass = 1'b1;
        end
      end else if (fail_clr) clr_seen = 1;
    end
  end

  task automatic fill_rect(input int clo, input int chi, input int dlo, input int dhi);
    for (int c = 0; c < 15; c++) begin
      pm[c] = '0;
      if (c >= clo && c <= chi)
        for (int d = dlo; d <= dhi; d++) pm[c][d] = 1'b1;
    end
  endtask

  task automatic expect_of(output int eci, output int edi, output int ep, output int et);
    int cnt [15];
    int best = 0, lo = -1, hi = -1, m, dlo, dhi;
    logic [6:0] row;
    for (int c = 0; c < 15; c++) cnt[c] = $countones(pm[c]);
    for (int k = 7; k >= 1 && lo < 0; k--) begin
      for (int c = 0; c < 15; c++)
        if (cnt[c] == k) begin
          if (lo < 0) lo = c;
          hi = c;
        end
      if (lo >= 0) best = k;
    end
    if (lo < 0) begin
      eci = 7; edi = 3; et = 106; ep = pm[7][3];
      return;
    end
    et = 113;
    m = mid_of(lo, hi, 15);
    if (cnt[m] < best) m = lo;
    eci = m;
    row = line_kill ? 7'd0 : pm[m];
    dlo = -1; dhi = -1;
    for (int d = 0; d < 7; d++)
      if (row[d]) begin
        if (dlo < 0) dlo = d;
        dhi = d;
      end
    if (dlo < 0) begin
      eci = 7; edi = 3;
    end else begin
      edi = mid_of(dlo, dhi, 7);
      if (!row[edi]) edi = dlo;
    end
    ep = pm[eci][edi];
  endtask

  task automatic run_case(input string name, input bit kill, input int mute);
    int eci, edi, ep, et, n;
    int hc, hd, hp;
    line_kill = kill;
    mute_at = mute;
    expect_of(eci, edi, ep, et);
    line_expected = (et == 113);
    go_count = 0; clr_bad = 0; order_bad = 0; clr_seen = 0;
    @(negedge clk) start = 1'b1;
    @(negedge clk) start = 1'b0;
    n = 0;
    while (!done && n < 20000) begin
      @(negedge clk);
      n++;
    end
    $display("case %s: cycles=%0d", name, n);
    chk("R9", "done raised", done, 1);
    chk("R9", "busy low at done", busy, 0);
    chk("R3", "fail_clr before every test_go", clr_bad, 0);
    if (mute > 0) begin
      chk("R10", "timeout pass", pass, 0);
      chk("R10", "tests issued before abort", go_count, mute);
    end else begin
      chk("R2", "grid/line order", order_bad, 0);
      chk("R2", "test count", go_count, et);
      chk("R5", "clk index", clk_idx, eci);
      chk("R7", "dqs index", dqs_idx, edi);
      chk("R2", "clk code", clk_code, ccode(eci));
      chk("R2", "dqs code", dqs_code, dcode(edi));
      chk("R9", "final pass", pass, ep);
    end
    hc = clk_idx; hd = dqs_idx; hp = pass;
    repeat (6) @(negedge clk);
    chk("R11", "hold clk index", clk_idx, hc);
    chk("R11", "hold dqs index", dqs_idx, hd);
    chk("R11", "hold pass/done", {pass, done}, {hp[0], 1'b1});
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R1", "reset outputs", {busy, done, pass, test_go, fail_clr}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1", "idle after reset", {busy, done, pass, test_go, fail_clr}, 0);

    fill_rect(3, 9, 1, 5);   run_case("interior R5", 0, -1);
    fill_rect(0, 4, 2, 4);   run_case("low edge R5", 0, -1);
    fill_rect(10, 14, 4, 6); run_case("high edge R5 R7", 0, -1);
    fill_rect(0, 14, 0, 6);  run_case("all pass R5", 0, -1);
    fill_rect(0, -1, 0, 0);  run_case("none pass R8 R4", 0, -1);
    // weak centre: rows 2,6 full, row 4 partial -> lowest index (R6)
    fill_rect(0, -1, 0, 0);
    pm[2] = 7'h7F; pm[6] = 7'h7F; pm[4] = 7'h07;
    run_case("weak centre R6", 0, -1);
    // gapped strobe row: only strobe 0 and 6 pass -> centre fails, lowest (R7)
    fill_rect(0, -1, 0, 0);
    pm[5] = 7'h41;
    run_case("strobe gap R7", 0, -1);
    fill_rect(3, 9, 1, 5);   run_case("strobe sweep fails R8", 1, -1);
    fill_rect(3, 9, 1, 5);   run_case("muted engine R10", 0, 5);
    fill_rect(1, 13, 2, 6);  run_case("restart after abort R5", 0, -1);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule